// File: doc/BRIEF.md
# Multiplexed Bus Cycle Demultiplexer

This block sits beside a processor that shares one 8-bit set of pins for three things in turn: the low address byte, then the high address byte with two cycle-type bits, then the data byte. It watches the processor's 3-bit state code and the shared bus. It keeps a 14-bit address and the 2-bit cycle type in registers, so that memories and I/O devices see a stable address.

During the data state it raises one strobe. The strobe is memory read, memory write, I/O input or I/O output, and an extra flag marks opcode fetches. For I/O commands the direction comes from the port number. A port number below 8 is an input, and any other port number is an output.

The block also drives the processor's ready input. After the high-address state of a memory cycle it holds ready low for a programmable number of clocks. This lets a slow memory finish before the processor moves on to the data state.

Top module: `bus_cycle_demux`

## Requirements
- R1: After a synchronous active-low reset, addr is 0, cyc_type is 0, ready is 1 and mem_rd, mem_wr, io_rd, io_wr and op_fetch are all 0.
- R2: When state is 010 (low address) or 110 (low address, interrupt acknowledged) at a clock edge, addr[7:0] takes bus_in[7:0] from the next cycle on.
- R3: When state is 100 (high address) at a clock edge, addr[13:8] takes bus_in[5:0] and cyc_type takes bus_in[7:6] from the next cycle on. The cyc_type encoding is 00 opcode fetch, 10 memory read, 01 I/O command and 11 memory write.
- R4: In states 000, 001, 011, 101 and 111, addr and cyc_type keep their values.
- R5: While state is 001 (data), cyc_type 00 or 10 asserts mem_rd and cyc_type 11 asserts mem_wr. op_fetch is asserted only for cyc_type 00.
- R6: io_port always shows addr[13:9]. While state is 001 and cyc_type is 01, io_rd is asserted if io_port < 8, and io_wr is asserted otherwise.
- R7: In any state other than 001, no strobe (mem_rd, mem_wr, io_rd, io_wr, op_fetch) is asserted, and at most one of the four direction strobes is ever high.
- R8: After a high-address edge with a memory cycle type (00, 10 or 11) and latency_cfg = N, ready is 0 for exactly the next N cycles and then returns to 1. N = 0 gives no wait cycle.
- R9: A high-address edge with cyc_type 01 (I/O) leaves ready at 1 in the following cycle, even if a count was running.
- R10: latency_cfg is sampled only at the high-address edge. Changing it while ready is low does not change the number of wait cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| state | input | 3 | Processor state code |
| bus_in | input | 8 | Shared address/type/data bus |
| latency_cfg | input | 4 | Wait cycles inserted for memory cycles |
| addr | output | 14 | Latched address |
| cyc_type | output | 2 | Latched cycle type {cc2,cc1} |
| mem_rd | output | 1 | Memory read strobe (data state) |
| mem_wr | output | 1 | Memory write strobe (data state) |
| io_rd | output | 1 | I/O input strobe (data state) |
| io_wr | output | 1 | I/O output strobe (data state) |
| op_fetch | output | 1 | Opcode fetch indicator (data state) |
| io_port | output | 5 | Port number, addr[13:9] |
| ready | output | 1 | Ready to the processor |

## Verification
The bench goes after the port-number boundary between 7 and 8, and the extreme values 0 and 31. A decoder with the wrong split would give an I/O output strobe for an input port, or the reverse. It checks that the low byte is captured in the interrupt-acknowledge variant of the low-address state and that the address holds through halt and internal states. A design that missed either would show a corrupted address. Wait counting is checked with latency 0, with small values and with latency_cfg changed while ready is low. An off-by-one counter, one that reloads late, or one that stalls I/O cycles would show a wrong number of wait cycles.

// File: rtl/bcd_pkg.sv
// Package: state codes and cycle-type codes shared by the bus demultiplexer.
// Assumes a 3-bit processor state code and a 2-bit cycle type {cc2,cc1}.
package bcd_pkg;
    localparam logic [2:0] ST_WAIT = 3'b000;
    localparam logic [2:0] ST_DATA = 3'b001;
    localparam logic [2:0] ST_LOW  = 3'b010;
    localparam logic [2:0] ST_STOP = 3'b011;
    localparam logic [2:0] ST_HIGH = 3'b100;
    localparam logic [2:0] ST_INT5 = 3'b101;
    localparam logic [2:0] ST_LOWI = 3'b110;
    localparam logic [2:0] ST_INT4 = 3'b111;

    localparam logic [1:0] CC_FETCH = 2'b00;
    localparam logic [1:0] CC_MREAD = 2'b10;
    localparam logic [1:0] CC_IOCMD = 2'b01;
    localparam logic [1:0] CC_MWRIT = 2'b11;
endpackage

// File: rtl/bcd_addr_latch.sv
// Address/type capture: takes the low address byte in either low-address
// state and the high address bits plus cycle type in the high-address state.
// Assumes the high byte carries the type in its top two bits and the
// address in the bits below.
module bcd_addr_latch
    import bcd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        state,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        cyc_type
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic [DATA_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;
    logic [1:0]        cc_q;

    // Purpose: capture the low byte in either low-address state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_q <= '0;
        else if (state == ST_LOW || state == ST_LOWI)
            lo_q <= bus_in;
    end

    // Purpose: capture the high address bits and the cycle type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            cc_q <= CC_FETCH;
        end else if (state == ST_HIGH) begin
            hi_q <= bus_in[HI_W-1:0];
            cc_q <= bus_in[DATA_W-1 -: 2];
        end
    end

    assign addr     = {hi_q, lo_q};
    assign cyc_type = cc_q;

    // R2: the low byte follows the bus after a low-address edge.
    a_r2_low_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW || state == ST_LOWI) |=> addr[DATA_W-1:0] == $past(bus_in));

    // R3: the high bits and type follow the bus after a high-address edge.
    a_r3_high_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH) |=> (addr[ADDR_W-1:DATA_W] == $past(bus_in[HI_W-1:0]))
                               && (cyc_type == $past(bus_in[DATA_W-1 -: 2])));

    // R4: the address and type hold in every other state.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == ST_LOW || state == ST_LOWI || state == ST_HIGH)
        |=> ($stable(addr) && $stable(cyc_type)));
endmodule

// File: rtl/bcd_strobe_dec.sv
// Strobe decoder: in the data state, turns the latched cycle type and port
// number into one direction strobe plus the opcode-fetch flag.
// Assumes the I/O port number sits in the top PORT_W address bits and that
// ports below IN_PORTS are inputs.
module bcd_strobe_dec
    import bcd_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int PORT_W   = 5,
    parameter int IN_PORTS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        state,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        cyc_type,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr,
    output logic              op_fetch,
    output logic [PORT_W-1:0] io_port
);
    localparam logic [PORT_W-1:0] IN_LIMIT = PORT_W'(IN_PORTS);

    logic data_st;
    logic is_input;

    assign io_port  = addr[ADDR_W-1 -: PORT_W];
    assign data_st  = (state == ST_DATA);
    assign is_input = (io_port < IN_LIMIT);

    // Purpose: decode the cycle type into strobes during the data state.
    always_comb begin
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        io_rd    = 1'b0;
        io_wr    = 1'b0;
        op_fetch = 1'b0;
        if (data_st) begin
            case (cyc_type)
                CC_FETCH: begin
                    mem_rd   = 1'b1;
                    op_fetch = 1'b1;
                end
                CC_MREAD: mem_rd = 1'b1;
                CC_MWRIT: mem_wr = 1'b1;
                default: begin
                    io_rd = is_input;
                    io_wr = !is_input;
                end
            endcase
        end
    end

    // R7: at most one direction strobe is high at a time.
    a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr, io_rd, io_wr}));

    // R5: an opcode fetch is always also a memory read.
    a_r5_fetch_reads: assert property (@(posedge clk) disable iff (!rst_n)
        op_fetch |-> mem_rd);

    // R6: the I/O direction matches the port-number boundary.
    a_r6_io_direction: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd |-> io_port < IN_LIMIT) and (io_wr |-> io_port >= IN_LIMIT));
endmodule

// File: rtl/bcd_wait_gen.sv
// Wait generator: after the high-address state of a memory cycle, holds
// ready low for the programmed number of clocks.
// Assumes the cycle type is taken from the bus in that same state, and that
// an I/O cycle clears any wait still running.
module bcd_wait_gen
    import bcd_pkg::*;
#(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       state,
    input  logic [1:0]       bus_cc,
    input  logic [LAT_W-1:0] latency_cfg,
    output logic             ready
);
    logic [LAT_W-1:0] cnt_q;
    logic             load;

    assign load  = (state == ST_HIGH);
    assign ready = (cnt_q == '0);

    // Purpose: load the wait count at the high-address state, then count down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= (bus_cc == CC_IOCMD) ? '0 : latency_cfg;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - LAT_W'(1);
    end

    // R8: a running count falls by one per clock.
    a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - LAT_W'(1));

    // R9: an I/O cycle never brings ready low.
    a_r9_io_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (load && bus_cc == CC_IOCMD) |=> ready);

    // R10: outside a high-address edge, ready only rises or stays.
    a_r10_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && ready) |=> ready);
endmodule

// File: rtl/bus_cycle_demux.sv
// Top level of the bus demultiplexer: address/type latch, strobe decoder
// and wait generator.
// Assumes the processor presents the state code and bus as synchronous
// inputs and samples ready on the clock.
module bus_cycle_demux
    import bcd_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 14,
    parameter int PORT_W   = 5,
    parameter int IN_PORTS = 8,
    parameter int LAT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        state,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [LAT_W-1:0]  latency_cfg,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        cyc_type,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr,
    output logic              op_fetch,
    output logic [PORT_W-1:0] io_port,
    output logic              ready
);
    bcd_addr_latch #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .state(state), .bus_in(bus_in),
        .addr(addr), .cyc_type(cyc_type)
    );

    bcd_strobe_dec #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .IN_PORTS(IN_PORTS)) u_dec (
        .clk(clk), .rst_n(rst_n), .state(state), .addr(addr), .cyc_type(cyc_type),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
        .op_fetch(op_fetch), .io_port(io_port)
    );

    bcd_wait_gen #(.LAT_W(LAT_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .state(state),
        .bus_cc(bus_in[DATA_W-1 -: 2]), .latency_cfg(latency_cfg), .ready(ready)
    );

    // R7: no strobe outside the data state.
    a_r7_quiet_outside_data: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_DATA) |-> !(mem_rd || mem_wr || io_rd || io_wr || op_fetch));
endmodule

// File: tb/test_bus_cycle_demux.sv
`timescale 1ns/1ps
module test_bus_cycle_demux;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  state = 3'b011;
    logic [7:0]  bus_in = 8'h00;
    logic [3:0]  latency_cfg = 4'd0;
    logic [13:0] addr;
    logic [1:0]  cyc_type;
    logic        mem_rd, mem_wr, io_rd, io_wr, op_fetch, ready;
    logic [4:0]  io_port;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // Behavioural reference state.
    int m_lo = 0, m_hi = 0, m_cc = 0, m_cnt = 0;

    always #4 clk = ~clk;

    bus_cycle_demux i_bus_cycle_demux (
        .clk(clk), .rst_n(rst_n), .state(state), .bus_in(bus_in),
        .latency_cfg(latency_cfg), .addr(addr), .cyc_type(cyc_type),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
        .op_fetch(op_fetch), .io_port(io_port), .ready(ready)
    );

    // Reference model update, from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo = 0; m_hi = 0; m_cc = 0; m_cnt = 0;
        end else begin
            if (state == 3'b010 || state == 3'b110) m_lo = bus_in;
            if (state == 3'b100) begin
                m_hi = bus_in & 8'h3F;
                m_cc = bus_in >> 6;
                m_cnt = (m_cc == 1) ? 0 : latency_cfg;
            end else if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Compare every port with the reference for the current cycle.
    task automatic compare();
        int port, e_mr, e_mw, e_ir, e_iw, e_of;
        port = m_hi >> 1;
        e_mr = 0; e_mw = 0; e_ir = 0; e_iw = 0; e_of = 0;
        if (state == 3'b001) begin
            if (m_cc == 0) begin e_mr = 1; e_of = 1; end
            else if (m_cc == 2) e_mr = 1;
            else if (m_cc == 3) e_mw = 1;
            else if (port < 8) e_ir = 1;
            else e_iw = 1;
        end
        chk("R2/R3/R4 addr", addr, m_hi * 256 + m_lo);
        chk("R3/R4 cyc_type", cyc_type, m_cc);
        chk("R5/R7 mem_rd", mem_rd, e_mr);
        chk("R5/R7 mem_wr", mem_wr, e_mw);
        chk("R5/R7 op_fetch", op_fetch, e_of);
        chk("R6/R7 io_rd", io_rd, e_ir);
        chk("R6/R7 io_wr", io_wr, e_iw);
        chk("R6 io_port", io_port, port);
        chk("R8 ready", ready, (m_cnt == 0) ? 1 : 0);
    endtask

    task automatic step(input logic [2:0] st, input logic [7:0] b);
        @(negedge clk);
        state = st; bus_in = b;
        #1 compare();
    endtask

    // One processor bus cycle: low, high, waits, data, then internal states.
    task automatic bus_cycle(input logic [2:0] low_st, input logic [13:0] a,
                             input logic [1:0] cc, input logic [3:0] lat,
                             input int new_lat, input logic [7:0] data,
                             input int exp_waits, input string tag);
        int waits = 0;
        step(low_st, a[7:0]);
        latency_cfg = lat;
        step(3'b100, {cc, a[13:8]});
        forever begin
            @(negedge clk);
            if (ready) break;
            if (new_lat >= 0) latency_cfg = new_lat[3:0];
            state = 3'b000; bus_in = 8'hA5;
            waits++;
            #1 compare();
        end
        state = 3'b001; bus_in = data;
        #1 compare();
        chk(tag, waits, exp_waits);
        step(3'b111, 8'h5A);
        step(3'b101, 8'hC3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state.
        chk("R1 addr", addr, 0);
        chk("R1 cyc_type", cyc_type, 0);
        chk("R1 ready", ready, 1);
        chk("R1 strobes", {mem_rd, mem_wr, io_rd, io_wr, op_fetch}, 0);
        @(negedge clk); rst_n = 1'b1;

        // R5 fetch, no wait (R8 with N=0).
        bus_cycle(3'b010, 14'h1234, 2'b00, 4'd0, -1, 8'h00, 0, "R8 zero latency");
        // R2 interrupt-acknowledge low state, memory read, 3 waits.
        bus_cycle(3'b110, 14'h2ABC, 2'b10, 4'd3, -1, 8'h11, 3, "R8 three waits");
        // Memory write, 1 wait.
        bus_cycle(3'b010, 14'h3FFF, 2'b11, 4'd1, -1, 8'h22, 1, "R8 one wait");
        // R6 port 7 (input) and port 8 (output) boundary, with latency set (R9).
        bus_cycle(3'b010, {5'd7, 9'h055}, 2'b01, 4'd5, -1, 8'h33, 0, "R9 io input no wait");
        bus_cycle(3'b010, {5'd8, 9'h0AA}, 2'b01, 4'd5, -1, 8'h44, 0, "R9 io output no wait");
        bus_cycle(3'b010, {5'd0, 9'h000}, 2'b01, 4'd9, -1, 8'h45, 0, "R9 io port 0");
        bus_cycle(3'b010, {5'd31, 9'h1FF}, 2'b01, 4'd2, -1, 8'h46, 0, "R9 io port 31");
        // R10 latency change during a wait has no effect.
        bus_cycle(3'b010, 14'h0F0F, 2'b10, 4'd4, 15, 8'h55, 4, "R10 latency change ignored");
        bus_cycle(3'b010, 14'h0101, 2'b11, 4'd15, 1, 8'h56, 15, "R10 long latency kept");
        // R4 hold through stop, wait and internal states.
        for (int i = 0; i < 4; i++) step(3'b011, 8'hFF - i[7:0]);
        step(3'b101, 8'h00);
        step(3'b111, 8'h7E);
        step(3'b000, 8'h81);
        chk("R4 held addr", addr, 14'h0101);

        // Mixed pseudo-random cycles.
        for (int n = 0; n < 300; n++) begin
            logic [13:0] a;
            logic [1:0]  cc;
            logic [3:0]  lt;
            a  = 14'($urandom);
            cc = 2'($urandom);
            lt = 4'($urandom_range(0, 6));
            bus_cycle(($urandom_range(0, 1) != 0) ? 3'b010 : 3'b110, a, cc, lt, -1,
                      8'($urandom), (cc == 2'b01) ? 0 : int'(lt), "R8/R9 random cycle waits");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule